// File: doc/BRIEF.md
# Count/Compare Timer with Interrupt

This block is a free-running 32-bit up-counter paired with a 32-bit compare register. The count advances once for each cycle in which a tick-enable input is high. The tick models a fixed-rate time base. When an increment brings the count onto the compare value, a timer interrupt latches high. It stays high until software writes the compare register again. Software reaches both registers through a single-cycle write port, and the current count is always visible on a read-back output.

The latched interrupt is placed on one bit of an eight-line processor interrupt vector. The timer is peripheral source 5, and peripheral sources sit two lines above the processor's own, so it lands on processor line 7. A small 4-bit index output is also provided. It is taken from the low bits of a counter that advances on every clock, and serves as a cheap pseudo-random selector.

Top module: `count_compare_timer`

## Requirements
- R1: After synchronous reset the count reads 1, the compare register holds 0, the interrupt is low and the index output is 0.
- R2: With tick_en high the count increases by exactly one per clock and wraps from 0xFFFFFFFF to 0. With tick_en low and no write, the count holds.
- R3: A write with reg_sel = 0 loads reg_wdata into the count on the next edge. It leaves the compare value unchanged and takes priority over a tick in the same cycle.
- R4: The interrupt rises on the edge where a tick-driven increment makes the count equal the compare value.
- R5: Once high, the interrupt stays high through further ticks and through count writes.
- R6: A write with reg_sel = 1 loads the compare value and clears the interrupt on the next edge. A tick in that same cycle still advances the count, and no match is evaluated in that cycle.
- R7: Loading the count with a value equal to compare, or loading compare with a value equal to the count, raises no interrupt. The next match needs a full wrap of the count.
- R8: cpu_irq_lines bit 7 (peripheral source 5 plus offset 2) mirrors the timer interrupt, and all other bits stay 0.
- R9: rand_idx equals the low 4 bits of a counter that is cleared by reset and advances by one on every clock, independent of tick_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count advance enable, one increment per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 count, 1 compare |
| reg_wdata | input | 32 | Write data |
| count_rd | output | 32 | Current count value |
| timer_irq | output | 1 | Latched timer interrupt |
| cpu_irq_lines | output | 8 | Processor interrupt vector, timer on bit 7 |
| rand_idx | output | 4 | Low bits of the free-running index counter |

## Verification
The match logic is exercised in several ways. In one, the count ticks up to a compare value that lies a few steps ahead, which shows that the interrupt rises exactly on the matching increment and not one cycle early or late. In another, a value equal to the other register is loaded, either count onto compare or compare onto count, which separates a design that compares registers statically from one that detects only increments. Writes that coincide with a tick set write priority on the count apart from the count continuing to run across a compare write. A count near the top of its range, combined with the reset compare value of 0, confirms wrap-around matching.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W       = 32;
    localparam int IDX_W       = 4;
    localparam int FREE_W      = 8;
    localparam int NUM_LINES   = 8;
    localparam int PERIPH_SRC  = 5;
    localparam int LINE_OFFSET = 2;
    localparam int TIMER_LINE  = PERIPH_SRC + LINE_OFFSET;

    localparam logic [CNT_W-1:0] COUNT_RST   = CNT_W'(1);
    localparam logic [CNT_W-1:0] COMPARE_RST = '0;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_LD_CNT  = 2'd1,
        OP_LD_CMP  = 2'd2
    } reg_op_e;

    typedef struct packed {
        reg_op_e          op;
        logic [CNT_W-1:0] data;
    } reg_req_t;

    function automatic reg_req_t decode_req(input logic wr,
                                            input logic sel,
                                            input logic [CNT_W-1:0] d);
        reg_req_t r;
        r.data = d;
        if (!wr)
            r.op = OP_IDLE;
        else if (sel)
            r.op = OP_LD_CMP;
        else
            r.op = OP_LD_CNT;
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
        return v + CNT_W'(1);
    endfunction

endpackage

// File: rtl/tmr_count_reg.sv
module tmr_count_reg
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  reg_req_t         req,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_inc,
    output logic             inc_taken
);

    logic [CNT_W-1:0] count_d;

    always_comb begin
        count_inc = bump(count_q);
        inc_taken = 1'b0;
        count_d   = count_q;
        if (req.op == OP_LD_CNT) begin
            count_d = req.data;
        end else if (tick_en) begin
            count_d   = count_inc;
            inc_taken = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= COUNT_RST;
        else
            count_q <= count_d;
    end

    // R3: a count write lands exactly, regardless of tick
    assert_count_load_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && req.op == OP_LD_CNT) |=> count_q == $past(req.data));

    // R2: count holds with no tick and no count write
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst && !tick_en && req.op != OP_LD_CNT) |=> $stable(count_q));

endmodule

// File: rtl/tmr_match_latch.sv
module tmr_match_latch
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  reg_req_t         req,
    input  logic [CNT_W-1:0] count_inc,
    input  logic             inc_taken,
    output logic [CNT_W-1:0] compare_q,
    output logic             irq_q
);

    logic hit;

    always_comb begin
        hit = inc_taken && (req.op != OP_LD_CMP) && (count_inc == compare_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            compare_q <= COMPARE_RST;
            irq_q     <= 1'b0;
        end else if (req.op == OP_LD_CMP) begin
            compare_q <= req.data;
            irq_q     <= 1'b0;
        end else if (hit) begin
            irq_q <= 1'b1;
        end
    end

    // R6: compare write acknowledges the interrupt
    assert_cmp_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (!rst && req.op == OP_LD_CMP) |=> !irq_q);

    // R5: sticky until a compare write
    assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (!rst && irq_q && req.op != OP_LD_CMP) |=> irq_q);

endmodule

// File: rtl/tmr_free_idx.sv
module tmr_free_idx
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] idx
);

    logic [FREE_W-1:0] free_q;

    always_ff @(posedge clk) begin
        if (rst)
            free_q <= '0;
        else
            free_q <= free_q + FREE_W'(1);
    end

    assign idx = free_q[IDX_W-1:0];

    // R9: index advances by one every clock
    assert_idx_step_R9: assert property (@(posedge clk) disable iff (rst)
        !rst |=> idx == $past(idx) + IDX_W'(1));

endmodule

// File: rtl/tmr_irq_route.sv
module tmr_irq_route
    import tmr_pkg::*;
(
    input  logic                 irq_in,
    output logic [NUM_LINES-1:0] lines
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        if (g == TIMER_LINE) begin : g_tmr
            assign lines[g] = irq_in;
        end else begin : g_idle
            assign lines[g] = 1'b0;
        end
    end

    // R8: at most one line set, and only the timer line
    always_comb begin
        assert_route_R8: assert ($onehot0(lines) && (lines[TIMER_LINE] == irq_in));
    end

endmodule

// File: rtl/count_compare_timer.sv
module count_compare_timer
    import tmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_en,
    input  logic                 reg_wr,
    input  logic                 reg_sel,
    input  logic [CNT_W-1:0]     reg_wdata,
    output logic [CNT_W-1:0]     count_rd,
    output logic                 timer_irq,
    output logic [NUM_LINES-1:0] cpu_irq_lines,
    output logic [IDX_W-1:0]     rand_idx
);

    reg_req_t         req;
    logic [CNT_W-1:0] count_inc;
    logic             inc_taken;
    logic [CNT_W-1:0] compare_q;

    assign req = decode_req(reg_wr, reg_sel, reg_wdata);

    tmr_count_reg u_count (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .req       (req),
        .count_q   (count_rd),
        .count_inc (count_inc),
        .inc_taken (inc_taken)
    );

    tmr_match_latch u_match (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .count_inc (count_inc),
        .inc_taken (inc_taken),
        .compare_q (compare_q),
        .irq_q     (timer_irq)
    );

    tmr_free_idx u_idx (
        .clk (clk),
        .rst (rst),
        .idx (rand_idx)
    );

    tmr_irq_route u_route (
        .irq_in (timer_irq),
        .lines  (cpu_irq_lines)
    );

    // R4: a rising interrupt coincides with count sitting on compare
    assert_rise_on_match_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(timer_irq) |-> count_rd == compare_q);

    // R7: a register load never raises the interrupt
    assert_no_fire_on_load_R7: assert property (@(posedge clk) disable iff (rst)
        (!rst && reg_wr && !timer_irq) |=> !timer_irq);

endmodule

// File: tb/count_compare_timer_tb_top.sv
module count_compare_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] count_rd;
    logic        timer_irq;
    logic [7:0]  cpu_irq_lines;
    logic [3:0]  rand_idx;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    count_compare_timer dut_i (
        .clk           (clk),
        .rst           (rst),
        .tick_en       (tick_en),
        .reg_wr        (reg_wr),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .count_rd      (count_rd),
        .timer_irq     (timer_irq),
        .cpu_irq_lines (cpu_irq_lines),
        .rand_idx      (rand_idx)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: act timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act %h exp %h", req, act, exp);
        end
    endtask

    task automatic cyc1();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        for (int i = 0; i < n; i++) cyc1();
        tick_en = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d, input logic tk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d; tick_en = tk;
        cyc1();
        reg_wr = 1'b0; tick_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc1();
        cyc1();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 count", count_rd, 32'd1);
        chk("R1 irq", {31'd0, timer_irq}, 32'd0);
        chk("R1 idx", {28'd0, rand_idx}, 32'd0);
        chk("R8 lines", {24'd0, cpu_irq_lines}, 32'd0);
    endtask

    task automatic t_match();
        wr(1'b1, 32'd105, 1'b0);
        wr(1'b0, 32'd100, 1'b0);
        ticks(4);
        chk("R2 count", count_rd, 32'd104);
        chk("R4 early", {31'd0, timer_irq}, 32'd0);
        ticks(1);
        chk("R4 fire", {31'd0, timer_irq}, 32'd1);
        chk("R8 line7", {24'd0, cpu_irq_lines}, 32'h80);
    endtask

    task automatic t_sticky();
        ticks(3);
        chk("R5 ticks", {31'd0, timer_irq}, 32'd1);
        chk("R2 run", count_rd, 32'd108);
        cyc1();
        chk("R2 hold", count_rd, 32'd108);
        wr(1'b0, 32'd7, 1'b0);
        chk("R5 cntwr", {31'd0, timer_irq}, 32'd1);
    endtask

    task automatic t_ack();
        wr(1'b1, 32'd500, 1'b1);
        chk("R6 clear", {31'd0, timer_irq}, 32'd0);
        chk("R6 run", count_rd, 32'd8);
        chk("R8 cleared", {24'd0, cpu_irq_lines}, 32'd0);
    endtask

    task automatic t_cmp_equal();
        wr(1'b1, 32'd8, 1'b0);
        chk("R7 cmp=cnt", {31'd0, timer_irq}, 32'd0);
        ticks(2);
        chk("R7 cmp later", {31'd0, timer_irq}, 32'd0);
        chk("R2 count", count_rd, 32'd10);
    endtask

    task automatic t_cnt_equal();
        wr(1'b1, 32'd300, 1'b0);
        wr(1'b0, 32'd300, 1'b1);
        chk("R3 priority", count_rd, 32'd300);
        chk("R7 cnt=cmp", {31'd0, timer_irq}, 32'd0);
        ticks(1);
        chk("R7 after", {31'd0, timer_irq}, 32'd0);
        chk("R3 keep cmp", count_rd, 32'd301);
    endtask

    task automatic t_cmp_tick_same();
        wr(1'b1, 32'd302, 1'b1);
        chk("R6 no eval", count_rd, 32'd302);
        chk("R6 no eval irq", {31'd0, timer_irq}, 32'd0);
    endtask

    task automatic t_wrap();
        do_reset();
        wr(1'b0, 32'hFFFF_FFFE, 1'b0);
        ticks(1);
        chk("R2 top", count_rd, 32'hFFFF_FFFF);
        chk("R4 not yet", {31'd0, timer_irq}, 32'd0);
        ticks(1);
        chk("R2 wrap", count_rd, 32'd0);
        chk("R1 cmp0 fire", {31'd0, timer_irq}, 32'd1);
    endtask

    task automatic t_idx();
        logic [3:0] a;
        do_reset();
        a = rand_idx;
        for (int i = 0; i < 20; i++) cyc1();
        chk("R9 step", {28'd0, rand_idx}, {28'd0, a + 4'd4});
        tick_en = 1'b1;
        cyc1();
        tick_en = 1'b0;
        chk("R9 tick ind", {28'd0, rand_idx}, {28'd0, a + 4'd5});
    endtask

    initial begin
        t_reset();
        t_match();
        t_sticky();
        t_ack();
        t_cmp_equal();
        t_cnt_equal();
        t_cmp_tick_same();
        t_wrap();
        t_idx();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule